// File: doc/BRIEF.md
# Exception Entry Vector Unit

This block sits beside the fetch stage of a simple in-order core and turns fault requests into a fetch redirect. Each cycle the core presents a bit vector of pending fault classes, the PC of the faulting instruction, a flag saying whether the core already runs in privileged mode, and a trap attribute. The block picks one class by fixed priority. It maps that class to a constant vector offset and adds the offset to a handler-base register. One cycle later it emits a single-cycle redirect pulse together with the handler PC and the sequential PC after it.

The block also keeps the exception return address. It captures the faulting PC when the core is outside privileged mode, or when the selected class always demands a fresh return address. For trap-type faults it moves that address one instruction past the faulting one. Every class has its own event counter, which can be read through a select port. The handler base is loaded through a one-word write port.

Top module: `evu_top`

## Requirements
- R1: When a fault is taken, `redirect_pc` equals the handler base plus the class offset. By class index 0..15 the offsets are 0x0001, 0x0401, 0x0081, 0x0101, 0x0181, 0x0181, 0x0201, 0x0281, 0x0301, 0x0381, 0x0381, 0x0481, 0x0501, 0x0501, 0x0581 and 0x2001. Bit k of `fault_vec` requests class k.
- R2: When several bits of `fault_vec` are set in one cycle, the lowest index is taken and reported on `taken_class`. Index 0 is reset, index 1 is machine check, and indices 2..15 rise with the vector offset.
- R3: `next_pc` equals `redirect_pc` plus 4 whenever `redirect` is high.
- R4: The return address `epc` is loaded with `pc_in` when `priv_in` is low, or when the taken class is in the force set. The force set is every class except 3 (interrupt) and 15 (privileged call).
- R5: When `skip_in` is high, the return address gains 4. If it was captured this cycle, it becomes `pc_in`+4. If it was not captured, it becomes the held value plus 4.
- R6: When a fault is taken from privileged mode by a non-forcing class with `skip_in` low, `epc` keeps its value. `epc` never changes in a cycle after one with no fault request.
- R7: `redirect` is high for exactly the cycle after each cycle with at least one request bit set, and low otherwise.
- R8: The counter of the taken class increments by one per taken fault, and classes that lose priority are not counted. `cnt_val` shows the counter selected by `cnt_sel` in the same cycle. With the default parameters, counters are 8 bits wide and wrap to 0.
- R9: `base_we` loads `base_wdata` into the handler base at the clock edge. A fault requested in that same cycle still uses the previous base.
- R10: After reset, `redirect` is 0, `epc` is 0, all counters are 0, and the handler base equals `BASE_RST` (default 0x0000_8000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_vec | input | 16 | One request bit per fault class |
| pc_in | input | AW | PC of the faulting instruction |
| priv_in | input | 1 | Core is in privileged mode |
| skip_in | input | 1 | Trap attribute: return past the faulting instruction |
| base_we | input | 1 | Handler-base write enable |
| base_wdata | input | AW | New handler-base value |
| cnt_sel | input | 4 | Class whose counter is shown |
| redirect | output | 1 | One-cycle fetch redirect and flush |
| redirect_pc | output | AW | Handler entry PC |
| next_pc | output | AW | Sequential PC after the handler entry |
| taken_class | output | 4 | Index of the class taken |
| epc | output | AW | Exception return address |
| cnt_val | output | CNTW | Event count of the selected class |

## Verification
The bench goes after classes that share an offset, and a design that merged or misordered them would redirect to the wrong handler. It fires all sixteen request bits together and other mixed patterns, and a wrong priority encoder would report a higher index and count the losing class. It takes non-forcing faults from privileged mode with and without the trap attribute. A design that always captured the PC, or skipped the increment on a held address, would show a wrong `epc`. It also writes the base in the same cycle as a fault, and a design that bypassed the new base would jump early. Finally it runs one counter past its width, and a saturating or missing-carry counter would read back the wrong value.

// File: rtl/evu_pkg.sv
package evu_pkg;

   localparam int NCLS = 16;
   localparam int CW   = 4;
   localparam int OFFW = 14;

   typedef enum logic [CW-1:0] {
      CLS_RESET   = 4'd0,
      CLS_MCHK    = 4'd1,
      CLS_IACV    = 4'd2,
      CLS_INTR    = 4'd3,
      CLS_IMISS   = 4'd4,
      CLS_IPAGE   = 4'd5,
      CLS_DMISS1  = 4'd6,
      CLS_DMISS2  = 4'd7,
      CLS_ALIGN   = 4'd8,
      CLS_DPAGE   = 4'd9,
      CLS_DACV    = 4'd10,
      CLS_ILLOP   = 4'd11,
      CLS_ARITH   = 4'd12,
      CLS_OVF     = 4'd13,
      CLS_FPOFF   = 4'd14,
      CLS_PRIVCAL = 4'd15
   } evu_cls_e;

   function automatic logic [OFFW-1:0] cls_offset(input logic [CW-1:0] c);
      logic [OFFW-1:0] o;
      case (evu_cls_e'(c))
         CLS_RESET:   o = 14'h0001;
         CLS_MCHK:    o = 14'h0401;
         CLS_IACV:    o = 14'h0081;
         CLS_INTR:    o = 14'h0101;
         CLS_IMISS,
         CLS_IPAGE:   o = 14'h0181;
         CLS_DMISS1:  o = 14'h0201;
         CLS_DMISS2:  o = 14'h0281;
         CLS_ALIGN:   o = 14'h0301;
         CLS_DPAGE,
         CLS_DACV:    o = 14'h0381;
         CLS_ILLOP:   o = 14'h0481;
         CLS_ARITH,
         CLS_OVF:     o = 14'h0501;
         CLS_FPOFF:   o = 14'h0581;
         default:     o = 14'h2001;
      endcase
      return o;
   endfunction

endpackage

// File: rtl/evu_prio.sv
module evu_prio #(
   parameter int N = 16,
   parameter int W = 4
) (
   input  logic [N-1:0] req,
   output logic         any,
   output logic [W-1:0] idx
);
   if (N > (1 << W)) begin : g_bad
      $error("evu_prio: index width too small");
   end

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = W'(i);
      end
   end

   assign any = |req;
endmodule

// File: rtl/evu_target.sv
module evu_target
   import evu_pkg::*;
#(
   parameter int AW   = 32,
   parameter int ISZ  = 4
) (
   input  logic [AW-1:0] base,
   input  logic [CW-1:0] cls,
   output logic [AW-1:0] hpc,
   output logic [AW-1:0] npc
);
   localparam int PADW = AW - OFFW;

   logic [AW-1:0] off_ext;

   assign off_ext = {{PADW{1'b0}}, cls_offset(cls)};
   assign hpc     = base + off_ext;
   assign npc     = hpc + AW'(ISZ);
endmodule

// File: rtl/evu_retaddr.sv
module evu_retaddr
   import evu_pkg::*;
#(
   parameter int              AW         = 32,
   parameter int              ISZ        = 4,
   parameter logic [NCLS-1:0] FORCE_MASK = 16'h7FF7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [CW-1:0] cls,
   input  logic [AW-1:0] pc,
   input  logic          priv,
   input  logic          skip,
   output logic [AW-1:0] epc
);
   logic          capture;
   logic [AW-1:0] src;
   logic [AW-1:0] nxt;

   assign capture = FORCE_MASK[cls] || !priv;
   assign src     = capture ? pc : epc;
   assign nxt     = skip ? (src + AW'(ISZ)) : src;

   always_ff @(posedge clk) begin
      if (!rst_n)    epc <= '0;
      else if (take) epc <= nxt;
   end
endmodule

// File: rtl/evu_counters.sv
module evu_counters #(
   parameter int N    = 16,
   parameter int W    = 4,
   parameter int CNTW = 8,
   parameter bit SAT  = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inc,
   input  logic [W-1:0]    inc_idx,
   input  logic [W-1:0]    rd_idx,
   output logic [CNTW-1:0] rd_val
);
   logic [CNTW-1:0] cnt [N];

   for (genvar g = 0; g < N; g++) begin : g_cnt
      logic hit;
      assign hit = inc && (inc_idx == W'(g));
      if (SAT) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)                   cnt[g] <= '0;
            else if (hit && ~&cnt[g])     cnt[g] <= cnt[g] + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)   cnt[g] <= '0;
            else if (hit) cnt[g] <= cnt[g] + 1'b1;
         end
      end
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < N; i++) begin
         if (rd_idx == W'(i)) rd_val = cnt[i];
      end
   end
endmodule

// File: rtl/evu_top.sv
module evu_top
   import evu_pkg::*;
#(
   parameter int              AW         = 32,
   parameter int              CNTW       = 8,
   parameter bit              CNT_SAT    = 1'b0,
   parameter logic [31:0]     BASE_RST   = 32'h0000_8000,
   parameter logic [NCLS-1:0] FORCE_MASK = 16'h7FF7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [15:0]     fault_vec,
   input  logic [AW-1:0]   pc_in,
   input  logic            priv_in,
   input  logic            skip_in,
   input  logic            base_we,
   input  logic [AW-1:0]   base_wdata,
   input  logic [3:0]      cnt_sel,
   output logic            redirect,
   output logic [AW-1:0]   redirect_pc,
   output logic [AW-1:0]   next_pc,
   output logic [3:0]      taken_class,
   output logic [AW-1:0]   epc,
   output logic [CNTW-1:0] cnt_val
);
   localparam int ISZ = 4;

   if (AW < 16) begin : g_aw_chk
      $error("evu_top: AW must hold the largest vector offset");
   end
   if (CNTW < 1) begin : g_cw_chk
      $error("evu_top: CNTW must be positive");
   end

   logic [AW-1:0] base_q;
   logic          any_req;
   logic [CW-1:0] win;
   logic [AW-1:0] hpc_c;
   logic [AW-1:0] npc_c;

   always_ff @(posedge clk) begin
      if (!rst_n)       base_q <= AW'(BASE_RST);
      else if (base_we) base_q <= base_wdata;
   end

   evu_prio #(.N(NCLS), .W(CW)) u_prio (
      .req (fault_vec),
      .any (any_req),
      .idx (win)
   );

   evu_target #(.AW(AW), .ISZ(ISZ)) u_target (
      .base (base_q),
      .cls  (win),
      .hpc  (hpc_c),
      .npc  (npc_c)
   );

   evu_retaddr #(.AW(AW), .ISZ(ISZ), .FORCE_MASK(FORCE_MASK)) u_ret (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (any_req),
      .cls   (win),
      .pc    (pc_in),
      .priv  (priv_in),
      .skip  (skip_in),
      .epc   (epc)
   );

   evu_counters #(.N(NCLS), .W(CW), .CNTW(CNTW), .SAT(CNT_SAT)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (any_req),
      .inc_idx (win),
      .rd_idx  (cnt_sel),
      .rd_val  (cnt_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redirect    <= 1'b0;
         redirect_pc <= '0;
         next_pc     <= '0;
         taken_class <= '0;
      end else begin
         redirect <= any_req;
         if (any_req) begin
            redirect_pc <= hpc_c;
            next_pc     <= npc_c;
            taken_class <= win;
         end
      end
   end
endmodule

// File: rtl/evu_chk.sv
module evu_chk
   import evu_pkg::*;
#(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic [15:0]   fault_vec,
   input logic [AW-1:0] pc_in,
   input logic          priv_in,
   input logic          skip_in,
   input logic [AW-1:0] base_q,
   input logic          redirect,
   input logic [AW-1:0] redirect_pc,
   input logic [AW-1:0] next_pc,
   input logic [3:0]    taken_class,
   input logic [AW-1:0] epc
);
   logic [15:0]   q_vec;
   logic [AW-1:0] q_pc;
   logic          q_priv;
   logic          q_skip;
   logic [AW-1:0] q_base;
   logic [15:0]   below;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_vec  <= '0;
         q_pc   <= '0;
         q_priv <= 1'b1;
         q_skip <= 1'b0;
         q_base <= '0;
      end else begin
         q_vec  <= fault_vec;
         q_pc   <= pc_in;
         q_priv <= priv_in;
         q_skip <= skip_in;
         q_base <= base_q;
      end
   end

   assign below = (16'd1 << taken_class) - 16'd1;

   assert_redirect_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (q_vec == '0) |-> !redirect);
   assert_redirect_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (q_vec != '0) |-> redirect);
   assert_seq_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> (next_pc == redirect_pc + AW'(4)));
   assert_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> (q_vec[taken_class] && ((q_vec & below) == '0)));
   assert_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> (redirect_pc == q_base + AW'(cls_offset(taken_class))));
   assert_user_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect && !q_priv) |-> (epc == q_pc + (q_skip ? AW'(4) : AW'(0))));
   assert_epc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (q_vec == '0) |-> $stable(epc));
endmodule

bind evu_top evu_chk #(.AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fault_vec   (fault_vec),
   .pc_in       (pc_in),
   .priv_in     (priv_in),
   .skip_in     (skip_in),
   .base_q      (base_q),
   .redirect    (redirect),
   .redirect_pc (redirect_pc),
   .next_pc     (next_pc),
   .taken_class (taken_class),
   .epc         (epc)
);

// File: tb/evu_top_tb.sv
module evu_top_tb;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [15:0]   fault_vec = '0;
   logic [AW-1:0] pc_in = '0;
   logic          priv_in = 1'b0;
   logic          skip_in = 1'b0;
   logic          base_we = 1'b0;
   logic [AW-1:0] base_wdata = '0;
   logic [3:0]    cnt_sel = '0;
   logic          redirect;
   logic [AW-1:0] redirect_pc;
   logic [AW-1:0] next_pc;
   logic [3:0]    taken_class;
   logic [AW-1:0] epc;
   logic [7:0]    cnt_val;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   evu_top u_dut (
      .clk(clk), .rst_n(rst_n), .fault_vec(fault_vec), .pc_in(pc_in),
      .priv_in(priv_in), .skip_in(skip_in), .base_we(base_we),
      .base_wdata(base_wdata), .cnt_sel(cnt_sel), .redirect(redirect),
      .redirect_pc(redirect_pc), .next_pc(next_pc), .taken_class(taken_class),
      .epc(epc), .cnt_val(cnt_val)
   );

   typedef struct {
      logic          red;
      logic [AW-1:0] hpc;
      logic [AW-1:0] npc;
      logic [3:0]    cls;
      logic [AW-1:0] epc;
      string         tag;
   } exp_t;

   exp_t exp_q[$];

   logic [AW-1:0] m_base = 32'h0000_8000;
   logic [AW-1:0] m_epc  = '0;
   logic [7:0]    m_cnt [16];

   function automatic logic [AW-1:0] offs(input int k);
      case (k)
         0: return 32'h0001;   1: return 32'h0401;
         2: return 32'h0081;   3: return 32'h0101;
         4: return 32'h0181;   5: return 32'h0181;
         6: return 32'h0201;   7: return 32'h0281;
         8: return 32'h0301;   9: return 32'h0381;
         10: return 32'h0381;  11: return 32'h0481;
         12: return 32'h0501;  13: return 32'h0501;
         14: return 32'h0581;  default: return 32'h2001;
      endcase
   endfunction

   task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic drive(input logic [15:0] v, input logic [AW-1:0] pc, input logic pv,
                        input logic sk, input logic bwe, input logic [AW-1:0] bd,
                        input string tag);
      exp_t e;
      int w;
      @(negedge clk);
      fault_vec = v; pc_in = pc; priv_in = pv; skip_in = sk;
      base_we = bwe; base_wdata = bd;
      e.red = (v != 0); e.tag = tag;
      e.hpc = '0; e.npc = '0; e.cls = '0;
      if (v != 0) begin
         w = 0;
         for (int i = 15; i >= 0; i--) if (v[i]) w = i;
         e.cls = 4'(w);
         e.hpc = m_base + offs(w);
         e.npc = e.hpc + 32'd4;
         if (!pv || (w != 3 && w != 15)) m_epc = pc;
         if (sk) m_epc = m_epc + 32'd4;
         m_cnt[w] = m_cnt[w] + 8'd1;
      end
      e.epc = m_epc;
      if (bwe) m_base = bd;
      exp_q.push_back(e);
   endtask

   task automatic idle();
      drive(16'h0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, "R7 idle");
   endtask

   task automatic chk_cnt(input int k, input string tag);
      @(negedge clk);
      cnt_sel = 4'(k);
      #2;
      check(tag, 32'(cnt_val), 32'(m_cnt[k]));
   endtask

   // monitor: one expected item per driven cycle
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " R7 redirect"}, 32'(redirect), 32'(e.red));
            if (e.red) begin
               check({e.tag, " R1 handler"}, redirect_pc, e.hpc);
               check({e.tag, " R3 next"}, next_pc, e.npc);
               check({e.tag, " R2 class"}, 32'(taken_class), 32'(e.cls));
            end
            check({e.tag, " epc"}, epc, e.epc);
         end
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) m_cnt[i] = 8'd0;
      repeat (3) @(negedge clk);
      #2;
      check("R10 reset redirect", 32'(redirect), 32'd0);
      check("R10 reset epc", epc, 32'd0);
      check("R10 reset cnt", 32'(cnt_val), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 every class alone, user mode: R4 captures
      for (int k = 0; k < 16; k++)
         drive(16'(1 << k), 32'h1000_0000 + 32'(k * 16), 1'b0, 1'b0, 1'b0, 32'h0, "R1 R4 single");
      idle();

      // R2 priority patterns
      drive(16'hFFFF, 32'h2000_0000, 1'b0, 1'b0, 1'b0, 32'h0, "R2 all");
      drive(16'b1010_0000, 32'h2000_0010, 1'b0, 1'b0, 1'b0, 32'h0, "R2 mix5");
      drive(16'h8100, 32'h2000_0020, 1'b0, 1'b0, 1'b0, 32'h0, "R2 mix8");
      drive(16'hC002, 32'h2000_0030, 1'b0, 1'b0, 1'b0, 32'h0, "R2 mix1");
      idle();

      // R4 R5 R6 return address rules
      drive(16'h0008, 32'h3000_0000, 1'b1, 1'b0, 1'b0, 32'h0, "R6 priv intr hold");
      drive(16'h8000, 32'h3000_0100, 1'b1, 1'b1, 1'b0, 32'h0, "R5 priv call held+4");
      drive(16'h0040, 32'h3000_0200, 1'b1, 1'b1, 1'b0, 32'h0, "R4 R5 forced capture+4");
      drive(16'h0008, 32'h3000_0300, 1'b0, 1'b1, 1'b0, 32'h0, "R4 R5 user intr+4");
      drive(16'h8000, 32'h3000_0400, 1'b1, 1'b0, 1'b0, 32'h0, "R6 priv call hold");
      idle();

      // R9 base write with simultaneous fault
      drive(16'h0010, 32'h4000_0000, 1'b0, 1'b0, 1'b1, 32'h0001_0000, "R9 old base");
      drive(16'h0010, 32'h4000_0004, 1'b0, 1'b0, 1'b0, 32'h0, "R9 new base");
      drive(16'h0000, 32'h0, 1'b0, 1'b0, 1'b1, 32'h0002_4000, "R9 write only");
      drive(16'h4000, 32'h4000_0008, 1'b0, 1'b0, 1'b0, 32'h0, "R9 second base");
      idle();
      idle();

      // R8 counters
      chk_cnt(0, "R8 cnt reset class");
      chk_cnt(1, "R8 cnt mchk");
      chk_cnt(3, "R8 cnt intr");
      chk_cnt(4, "R8 cnt imiss");
      chk_cnt(5, "R8 cnt ipage loser");
      chk_cnt(15, "R8 cnt privcall");

      // R8 wrap past 8 bits
      for (int n = 0; n < 256; n++)
         drive(16'h0200, 32'h5000_0000 + 32'(n * 4), 1'b0, 1'b0, 1'b0, 32'h0, "R8 wrap run");
      idle();
      idle();
      chk_cnt(9, "R8 cnt wrapped");
      chk_cnt(10, "R8 cnt shared offset");

      repeat (4) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule